// File: doc/BRIEF.md
# Pointer-Indexed Host Register Port

This block connects a slow asynchronous host bus to two on-chip storage spaces. The bus has a chip select, a read/write line, a 2-bit space/function select and an 8-bit data path. The first space is a file of 64 byte-wide working registers, which drive the rest of the chip through a flat output vector. The second is a byte-wide lookup memory with 256 locations. Each space is reached through its own index register. The host loads that index once, then streams data bytes through the matching data function. The index steps forward by itself after every byte.

All bus inputs are brought into the system clock domain through a two-flop synchroniser, and chip-select edges are detected there. A write takes its function and direction at the falling chip-select edge and its data byte at the rising edge. The captured byte is held as a pending commit and lands in its target only at the next falling chip-select edge, whatever access that edge begins. In a read, the output-enable goes high a few clocks after chip select falls and stays high until chip select rises. The pad tri-state is modelled by that enable alone.

Top module: `hreg_port`

## Requirements
- R1: After reset, `hp_oe` and `hp_dout` are 0, every working register in `cfg_flat` is 0, and both index registers read back as 0.
- R2: Function code 2'b00 writes the control index with bits [5:0] of the data byte, ignoring bits [7:6]. A read of code 2'b00 returns the index in bits [5:0], with bits [7:6] zero.
- R3: Function code 2'b01 writes and reads the full 8-bit table index.
- R4: A data byte written with code 2'b10 appears in `cfg_flat` only at the next chip-select falling edge, never at the rising edge that captured it. Register k occupies `cfg_flat[8k+7:8k]`.
- R5: The control index increases by one after each committed code-2'b10 write and saturates at 63. Further writes at 63 keep overwriting register 63 and leave every other register unchanged.
- R6: Code 2'b11 writes and reads the table location at the table index. Every committed table write steps the table index by one, and the index wraps from 255 to 0.
- R7: A data read (code 2'b10 or 2'b11) returns the location at the current index. It then advances that index when chip select rises, with the same saturation (control) or wrap (table) as writes.
- R8: `hp_oe` is high only during read accesses. It rises after chip select falls and drops within a cycle of the synchronised rising edge. It never rises in a write access.
- R9: The falling edge that begins a read first commits any pending write. The read therefore returns state that includes that write.
- R10: Reset discards a pending write, so no later chip-select edge commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_cs_n | input | 1 | Host chip select, active low, asynchronous |
| hp_rd | input | 1 | Host direction: 1 read, 0 write |
| hp_fn | input | 2 | Function: 00 control index, 01 table index, 10 control data, 11 table data |
| hp_din | input | 8 | Host write data, captured at chip-select rise |
| hp_dout | output | 8 | Read data, registered |
| hp_oe | output | 1 | Pad output enable for read data |
| cfg_flat | output | 512 | All 64 working registers, register k in bits [8k+7:8k] |

## Verification
The bench builds the block with its default sizes: 64 control registers, a 256-entry table and two synchroniser stages. These sizes are small enough to visit every location. The bench fills all 64 control registers in one autoincrementing burst, drives the index into its saturation point and writes there again. It writes and reads back all 256 table locations, so the table index wraps naturally. A short burst starting at 250 checks the wrap in both directions. Expected bytes come from simple arithmetic on the location number. Commit timing is checked by looking at `cfg_flat` between a write's rising edge and the next falling edge.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  typedef enum logic [1:0] {
    FN_CIDX = 2'b00,
    FN_TIDX = 2'b01,
    FN_CDAT = 2'b10,
    FN_TDAT = 2'b11
  } hfn_e;
endpackage

// File: rtl/hreg_sync.sv
module hreg_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hreg_ctrl_file.sv
module hreg_ctrl_file #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [AW-1:0]       raddr,
  output logic [DW-1:0]       rdata,
  output logic [DEPTH*DW-1:0] flat
);
  logic [DW-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) regs[waddr] <= wdata;
      rdata <= regs[raddr];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/hreg_tbl_mem.sv
module hreg_tbl_mem #(
  parameter int DW = 8,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hreg_port.sv
module hreg_port #(
  parameter int DW          = 8,
  parameter int CTRL_DEPTH  = 64,
  parameter int TBL_AW      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CAW        = $clog2(CTRL_DEPTH),
  localparam int FW         = 2,
  localparam int BUS_W      = 1 + 1 + FW + DW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hp_cs_n,
  input  logic                     hp_rd,
  input  logic [FW-1:0]            hp_fn,
  input  logic [DW-1:0]            hp_din,
  output logic [DW-1:0]            hp_dout,
  output logic                     hp_oe,
  output logic [CTRL_DEPTH*DW-1:0] cfg_flat
);
  import hreg_pkg::*;

  localparam logic [BUS_W-1:0] BUS_RST = {1'b1, {(BUS_W-1){1'b0}}};
  localparam logic [CAW-1:0]   CIDX_MAX = CAW'(CTRL_DEPTH - 1);

  // synchronised bus
  logic [BUS_W-1:0] bus_s;
  logic             cs_s, rd_s, cs_d;
  logic [FW-1:0]    fn_s;
  logic [DW-1:0]    din_s;

  hreg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({hp_cs_n, hp_rd, hp_fn, hp_din}),
    .q(bus_s)
  );
  assign {cs_s, rd_s, fn_s, din_s} = bus_s;

  always_ff @(posedge clk) begin
    if (rst) cs_d <= 1'b1;
    else     cs_d <= cs_s;
  end

  logic cs_fall, cs_rise;
  assign cs_fall = cs_d & ~cs_s;
  assign cs_rise = ~cs_d & cs_s;

  // access and commit state
  logic [CAW-1:0]    ctrl_idx;
  logic [TBL_AW-1:0] tbl_idx;
  hfn_e              acc_fn, pend_fn;
  logic              acc_rw;
  logic              pend;
  logic [DW-1:0]     pend_data;
  logic              rd_s1, rd_s2;

  logic cf_we, tm_we;
  assign cf_we = cs_fall & pend & (pend_fn == FN_CDAT);
  assign tm_we = cs_fall & pend & (pend_fn == FN_TDAT);

  logic [DW-1:0] cf_q, tm_q;

  hreg_ctrl_file #(.DW(DW), .DEPTH(CTRL_DEPTH)) u_cfile (
    .clk(clk), .rst(rst),
    .we(cf_we), .waddr(ctrl_idx), .wdata(pend_data),
    .raddr(ctrl_idx), .rdata(cf_q), .flat(cfg_flat)
  );

  hreg_tbl_mem #(.DW(DW), .AW(TBL_AW)) u_tmem (
    .clk(clk),
    .we(tm_we), .waddr(tbl_idx), .wdata(pend_data),
    .raddr(tbl_idx), .rdata(tm_q)
  );

  function automatic logic [CAW-1:0] cidx_step(input logic [CAW-1:0] v);
    return (v == CIDX_MAX) ? v : v + 1'b1;
  endfunction

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (acc_fn)
      FN_CIDX: rd_mux = DW'(ctrl_idx);
      FN_TIDX: rd_mux = DW'(tbl_idx);
      FN_CDAT: rd_mux = cf_q;
      default: rd_mux = tm_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_idx  <= '0;
      tbl_idx   <= '0;
      acc_fn    <= FN_CIDX;
      acc_rw    <= 1'b0;
      pend      <= 1'b0;
      pend_fn   <= FN_CIDX;
      pend_data <= '0;
      rd_s1     <= 1'b0;
      rd_s2     <= 1'b0;
      hp_dout   <= '0;
      hp_oe     <= 1'b0;
    end else begin
      rd_s1 <= 1'b0;
      rd_s2 <= rd_s1;
      if (rd_s2) begin
        hp_dout <= rd_mux;
        hp_oe   <= 1'b1;
      end
      if (cs_fall) begin
        if (pend) begin
          unique case (pend_fn)
            FN_CIDX: ctrl_idx <= pend_data[CAW-1:0];
            FN_TIDX: tbl_idx  <= TBL_AW'(pend_data);
            FN_CDAT: ctrl_idx <= cidx_step(ctrl_idx);
            default: tbl_idx  <= tbl_idx + 1'b1;
          endcase
        end
        pend   <= 1'b0;
        acc_fn <= hfn_e'(fn_s);
        acc_rw <= rd_s;
        rd_s1  <= rd_s;
      end
      if (cs_rise) begin
        if (!acc_rw) begin
          pend      <= 1'b1;
          pend_fn   <= acc_fn;
          pend_data <= din_s;
        end else begin
          hp_oe <= 1'b0;
          if (acc_fn == FN_CDAT) ctrl_idx <= cidx_step(ctrl_idx);
          if (acc_fn == FN_TDAT) tbl_idx  <= tbl_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hreg_port_chk.sv
module hreg_port_chk #(
  parameter int CAW   = 6,
  parameter int TAW   = 8,
  parameter int CFG_W = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             pend,
  input logic             acc_rw,
  input logic             hp_oe,
  input logic [CAW-1:0]   ctrl_idx,
  input logic [TAW-1:0]   tbl_idx,
  input logic [CFG_W-1:0] cfg_flat
);
  p_cidx_edge_only_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(cs_fall) && !$past(cs_rise)) |-> $stable(ctrl_idx));

  p_tidx_edge_only_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(cs_fall) && !$past(cs_rise)) |-> $stable(tbl_idx));

  p_cfg_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_flat) |-> $past(cs_fall));

  p_pend_drained_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && pend) |=> !pend);

  p_oe_drop_r8: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !hp_oe);

  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hp_oe) |-> acc_rw);
endmodule

bind hreg_port hreg_port_chk #(.CAW(CAW), .TAW(TBL_AW), .CFG_W(CTRL_DEPTH*DW)) u_chk (
  .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .pend(pend), .acc_rw(acc_rw), .hp_oe(hp_oe),
  .ctrl_idx(ctrl_idx), .tbl_idx(tbl_idx), .cfg_flat(cfg_flat)
);

// File: tb/test_hreg_port.sv
module test_hreg_port;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         hp_cs_n = 1'b1;
  logic         hp_rd = 1'b0;
  logic [1:0]   hp_fn = 2'b00;
  logic [7:0]   hp_din = 8'h00;
  logic [7:0]   hp_dout;
  logic         hp_oe;
  logic [511:0] cfg_flat;

  int n_cmp = 0;
  int n_bad = 0;
  logic oe_in_write = 1'b0;
  logic oe_stuck = 1'b0;

  always #4 clk = ~clk;

  hreg_port i_hreg_port (
    .clk(clk), .rst(rst), .hp_cs_n(hp_cs_n), .hp_rd(hp_rd), .hp_fn(hp_fn),
    .hp_din(hp_din), .hp_dout(hp_dout), .hp_oe(hp_oe), .cfg_flat(cfg_flat)
  );

  function automatic logic [7:0] fc(input int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] ft(input int i); return 8'((i * 29 + 3) & 255); endfunction
  function automatic logic [7:0] fw(input int i); return 8'((i * 11 + 200) & 255); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] creg(input int k); return cfg_flat[k*8 +: 8]; endfunction

  task automatic bus_wr(input logic [1:0] fn, input logic [7:0] d);
    @(negedge clk);
    hp_fn = fn; hp_rd = 1'b0; hp_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    if (hp_oe) oe_in_write = 1'b1;
    hp_din = d; hp_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] fn, output logic [7:0] d, output logic oe_seen);
    @(negedge clk);
    hp_fn = fn; hp_rd = 1'b1; hp_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    d = hp_dout; oe_seen = hp_oe;
    hp_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    if (hp_oe) oe_stuck = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    logic ok;
    do_reset();

    // R1 reset state
    chk("R1 oe", 32'(hp_oe), 0);
    chk("R1 dout", 32'(hp_dout), 0);
    chk("R1 cfg zero", 32'(cfg_flat == '0), 1);
    bus_rd(2'b00, d, oe); chk("R1 cidx", 32'(d), 0);
    bus_rd(2'b01, d, oe); chk("R1 tidx", 32'(d), 0);

    // R2 control index load keeps low six bits; R9 read commits it first
    bus_wr(2'b00, 8'hC7);
    bus_rd(2'b00, d, oe); chk("R2 cidx low bits", 32'(d), 32'h07);
    chk("R8 oe during read", 32'(oe), 1);

    // R4 / R5 burst over the whole control file
    bus_wr(2'b00, 8'h00);
    for (int i = 0; i < 64; i++) begin
      bus_wr(2'b10, fc(i));
      if (i == 0) chk("R4 no commit at rise", 32'(creg(0)), 0);
      if (i == 1) chk("R4 commit at next fall", 32'(creg(0)), 32'(fc(0)));
    end
    chk("R4 last still pending", 32'(creg(63)), 0);
    bus_rd(2'b00, d, oe); chk("R5 cidx saturated", 32'(d), 63);
    ok = 1'b1;
    for (int i = 0; i < 64; i++) if (creg(i) !== fc(i)) ok = 1'b0;
    chk("R5 burst contents", 32'(ok), 1);
    bus_wr(2'b10, 8'hAA);
    bus_wr(2'b10, 8'h55);
    bus_rd(2'b00, d, oe); chk("R5 cidx stays 63", 32'(d), 63);
    chk("R5 reg63 overwritten", 32'(creg(63)), 32'h55);
    chk("R5 reg62 untouched", 32'(creg(62)), 32'(fc(62)));

    // R7 control reads advance the index
    bus_wr(2'b00, 8'd10);
    for (int k = 0; k < 5; k++) begin
      bus_rd(2'b10, d, oe); chk("R7 ctrl read", 32'(d), 32'(fc(10 + k)));
    end
    bus_rd(2'b00, d, oe); chk("R7 cidx after reads", 32'(d), 15);
    bus_wr(2'b00, 8'd63);
    bus_rd(2'b10, d, oe); chk("R7 read at top", 32'(d), 32'h55);
    bus_rd(2'b00, d, oe); chk("R7 read saturates", 32'(d), 63);

    // R6 full table sweep
    bus_wr(2'b01, 8'h00);
    for (int i = 0; i < 256; i++) bus_wr(2'b11, ft(i));
    bus_rd(2'b01, d, oe); chk("R6 tidx wrapped by writes", 32'(d), 0);
    ok = 1'b1;
    for (int i = 0; i < 256; i++) begin
      bus_rd(2'b11, d, oe);
      if (d !== ft(i)) begin
        ok = 1'b0;
        $display("FAIL R6 table[%0d] actual=%0h expected=%0h", i, d, ft(i));
      end
    end
    chk("R6 table sweep", 32'(ok), 1);
    bus_rd(2'b01, d, oe); chk("R7 tidx wrapped by reads", 32'(d), 0);

    // R6 wrap in a short burst
    bus_wr(2'b01, 8'd250);
    for (int i = 0; i < 10; i++) bus_wr(2'b11, fw(i));
    bus_rd(2'b01, d, oe); chk("R6 tidx 250+10", 32'(d), 4);
    bus_wr(2'b01, 8'd250);
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      bus_rd(2'b11, d, oe);
      if (d !== fw(i)) ok = 1'b0;
    end
    chk("R6 wrap burst readback", 32'(ok), 1);
    bus_rd(2'b11, d, oe); chk("R6 untouched loc 4", 32'(d), 32'(ft(4)));

    // R3 table index full width
    bus_wr(2'b01, 8'h9E);
    bus_rd(2'b01, d, oe); chk("R3 tidx readback", 32'(d), 32'h9E);

    // R9 read right after a data write
    bus_wr(2'b00, 8'd40);
    bus_wr(2'b10, 8'h77);
    bus_rd(2'b00, d, oe); chk("R9 index includes pending", 32'(d), 41);
    chk("R9 reg40 committed", 32'(creg(40)), 32'h77);

    // R8 enable behaviour
    chk("R8 no oe in writes", 32'(oe_in_write), 0);
    chk("R8 oe drops after read", 32'(oe_stuck), 0);

    // R10 reset drops a pending write
    bus_wr(2'b00, 8'd5);
    bus_wr(2'b10, 8'h99);
    do_reset();
    chk("R10 cfg zero after reset", 32'(cfg_flat == '0), 1);
    bus_rd(2'b00, d, oe); chk("R10 cidx zero", 32'(d), 0);
    chk("R10 nothing committed", 32'(cfg_flat == '0), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule